// File: doc/BRIEF.md
# Multicycle Processor Datapath with Staged Registers

This block is the datapath of a 32-bit processor that runs each instruction as a series of short steps. Each step ends in a register with its own load enable. The instruction register holds the fetched word. Two operand registers and a one-bit equality flag are loaded from the register file. A result register holds the ALU output, and a memory-data register holds the word read back from data memory. The block also contains a register file with a hard-wired zero register, an ALU, zero and sign extension of the 16-bit immediate, and next-PC logic for sequential and branch updates.

The block never steps itself. An external controller drives one enable per register and a few select inputs, and it decides how many steps each instruction takes. Instruction memory and data memory sit outside the block. Both return read data in the same cycle as the address, and data memory is written on the clock edge. The instruction fields are fixed: rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, the function code in bits 5:0 and the immediate in bits 15:0. The opcode bits are not decoded here.

Top module: `mc_datapath`

## Requirements
- R1: While rst_ni is low, the block asynchronously clears PC, every staging register and every register-file entry to zero.
- R2: On a clock edge with ir_en_i high, the instruction register loads imem_rdata_i, the word at imem_addr_o, which always equals PC.
- R3: On a clock edge with opnd_en_i high, the A register loads register[rs] and the B register loads register[rt]. The equality flag loads 1 when the two are equal and 0 otherwise.
- R4: With alu_sel_i = 0, the ALU applies the function code to A and B: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0). Any other code gives zero.
- R5: With alu_sel_i = 1 the ALU gives A OR the zero-extended immediate. With 2 it gives A plus the sign-extended immediate. With 3 it gives zero.
- R6: The result register S loads the ALU output on a clock edge with s_en_i high, and dmem_addr_o always shows S.
- R7: On an edge with m_en_i high, the M register loads dmem_rdata_i. dmem_we_o follows mem_we_i, and dmem_wdata_o shows B, so a store writes B at address S.
- R8: With rf_we_i high, the register file writes on the clock edge. The address is rd when dst_sel_i = 1 and rt when it is 0. The data is M when wb_sel_i = 1 and S when it is 0.
- R9: Register 0 always reads zero, and writes to it are ignored.
- R10: On an edge with pc_en_i high, PC becomes PC+4. When branch_i is high and the equality flag is set, PC instead becomes PC + 4 + (sign-extended immediate × 4).
- R11: Each register holds its value on every edge where its enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Instruction memory address (PC) |
| imem_rdata_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data memory address (S register) |
| dmem_wdata_o | output | 32 | Data memory write data (B register) |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_rdata_i | input | 32 | Data memory read word at dmem_addr_o |
| ir_en_i | input | 1 | Load instruction register |
| opnd_en_i | input | 1 | Load A, B and equality flag |
| s_en_i | input | 1 | Load result register |
| alu_sel_i | input | 2 | ALU operand mode: 0 function, 1 OR zero-ext, 2 add sign-ext, 3 zero |
| m_en_i | input | 1 | Load memory-data register |
| mem_we_i | input | 1 | Store request |
| rf_we_i | input | 1 | Register file write |
| dst_sel_i | input | 1 | Destination: 1 rd, 0 rt |
| wb_sel_i | input | 1 | Write data: 1 M, 0 S |
| pc_en_i | input | 1 | Update PC |
| branch_i | input | 1 | Use the equality flag for the PC update |

## Verification
The bench sweeps every function code, including an unknown one, over pairs drawn from zero, one, the most negative value, all ones and mixed patterns. A wrong signed comparison shows up as an inverted set-less-than for sign-crossing pairs, and a missing default shows up as a nonzero result. Immediates with the top bit set are aimed at the extenders: a swapped extender would give a negative OR mask or an addition that is off by 64K. Branches are taken with positive and negative offsets, not taken on unequal operands, and suppressed with branch_i low. A design that ignored the flag or skipped the shift would end at the wrong PC. Writes to register 0, a rewrite of instruction memory without ir_en_i, and I-type writes whose rd field names a live register catch a leaky zero register, an ungated instruction register and a wrong destination select.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned IMM_W   = 16;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    ALU_FUNC = 2'd0,
    ALU_ORZ  = 2'd1,
    ALU_ADDS = 2'd2,
    ALU_NONE = 2'd3
  } alu_sel_e;

  typedef struct packed {
    logic [5:0]        op;
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] rd;
    logic [4:0]        sh;
    logic [5:0]        fn;
  } instr_t;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  localparam int unsigned NREG = 1 << AW;

  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // register 0 is forced to zero on read as well
  assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_q[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_q[raddr_b_i];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [5:0]       fn_i,
  input  alu_sel_e         sel_i,
  output logic [DW-1:0]    y_o
);
  logic [DW-1:0] zext, sext, fres;

  assign zext = {{(DW-IMM_W){1'b0}}, imm_i};
  assign sext = {{(DW-IMM_W){imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    unique case (fn_i)
      FN_ADD:  fres = a_i + b_i;
      FN_SUB:  fres = a_i - b_i;
      FN_AND:  fres = a_i & b_i;
      FN_OR:   fres = a_i | b_i;
      FN_SLT:  fres = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: fres = '0;
    endcase
  end

  always_comb begin
    unique case (sel_i)
      ALU_FUNC: y_o = fres;
      ALU_ORZ:  y_o = a_i | zext;
      ALU_ADDS: y_o = a_i + sext;
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_nextpc.sv
module mc_nextpc
  import mc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]    pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             take_i,
  output logic [DW-1:0]    npc_o
);
  logic [DW-1:0] seq, ofs;

  assign seq   = pc_i + DW'(4);
  assign ofs   = {{(DW-IMM_W-2){imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign npc_o = take_i ? seq + ofs : seq;
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] imem_addr_o,
  input  logic [31:0]       imem_rdata_i,
  output logic [DATA_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0] dmem_wdata_o,
  output logic              dmem_we_o,
  input  logic [DATA_W-1:0] dmem_rdata_i,
  input  logic              ir_en_i,
  input  logic              opnd_en_i,
  input  logic              s_en_i,
  input  logic [1:0]        alu_sel_i,
  input  logic              m_en_i,
  input  logic              mem_we_i,
  input  logic              rf_we_i,
  input  logic              dst_sel_i,
  input  logic              wb_sel_i,
  input  logic              pc_en_i,
  input  logic              branch_i
);
  logic [DATA_W-1:0]  pc_q, a_q, b_q, s_q, m_q;
  logic [INSTR_W-1:0] ir_q;
  logic               e_q;
  instr_t             ins;
  logic [DATA_W-1:0]  rs_val, rt_val, alu_y, npc, wb_data;
  logic [REG_AW-1:0]  wb_addr;

  assign ins     = instr_t'(ir_q);
  assign wb_addr = dst_sel_i ? ins.rd : ins.rt;
  assign wb_data = wb_sel_i ? m_q : s_q;

  mc_regfile #(.DW(DATA_W), .AW(REG_AW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we_i),
    .waddr_i   (wb_addr),
    .wdata_i   (wb_data),
    .raddr_a_i (ins.rs),
    .raddr_b_i (ins.rt),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val)
  );

  mc_alu #(.DW(DATA_W)) u_alu (
    .a_i   (a_q),
    .b_i   (b_q),
    .imm_i (ir_q[IMM_W-1:0]),
    .fn_i  (ins.fn),
    .sel_i (alu_sel_e'(alu_sel_i)),
    .y_o   (alu_y)
  );

  mc_nextpc #(.DW(DATA_W)) u_npc (
    .pc_i   (pc_q),
    .imm_i  (ir_q[IMM_W-1:0]),
    .take_i (branch_i & e_q),
    .npc_o  (npc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      e_q  <= 1'b0;
      s_q  <= '0;
      m_q  <= '0;
    end else begin
      if (pc_en_i)   pc_q <= npc;
      if (ir_en_i)   ir_q <= imem_rdata_i;
      if (opnd_en_i) begin
        a_q <= rs_val;
        b_q <= rt_val;
        e_q <= (rs_val == rt_val);
      end
      if (s_en_i)    s_q <= alu_y;
      if (m_en_i)    m_q <= dmem_rdata_i;
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = s_q;
  assign dmem_wdata_o = b_q;
  assign dmem_we_o    = mem_we_i;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] pc_q,
  input logic [31:0]       ir_q,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] b_q,
  input logic              e_q,
  input logic [DATA_W-1:0] s_q,
  input logic [31:0]       imem_rdata_i,
  input logic              ir_en_i,
  input logic              opnd_en_i,
  input logic              s_en_i,
  input logic              pc_en_i,
  input logic              branch_i
);
  // R11
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_en_i |=> $stable(pc_q));

  // R10
  pc_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_en_i && (!branch_i || !e_q)) |=> pc_q == $past(pc_q) + DATA_W'(4));

  // R2
  ir_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_en_i |=> ir_q == $past(imem_rdata_i));

  // R3
  eq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_en_i |=> e_q == (a_q == b_q));

  // R9
  zero_rs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opnd_en_i && ir_q[25:21] == 5'd0) |=> a_q == '0);

  // R6
  s_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_en_i |=> $stable(s_q));
endmodule

bind mc_datapath mc_datapath_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic        ir_en = 0, opnd_en = 0, s_en = 0, m_en = 0, mem_we = 0;
  logic        rf_we = 0, dst_sel = 0, wb_sel = 0, pc_en = 0, branch = 0;
  logic [1:0]  alu_sel = 0;
  logic        tb_we = 0;
  logic [5:0]  tb_wa = 0;
  logic [31:0] tb_wd = 0;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) begin
    if (tb_we)        dmem[tb_wa] <= tb_wd;
    else if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  mc_datapath uut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata), .dmem_we_o(dmem_we),
    .dmem_rdata_i(dmem_rdata),
    .ir_en_i(ir_en), .opnd_en_i(opnd_en), .s_en_i(s_en), .alu_sel_i(alu_sel),
    .m_en_i(m_en), .mem_we_i(mem_we), .rf_we_i(rf_we), .dst_sel_i(dst_sel),
    .wb_sel_i(wb_sel), .pc_en_i(pc_en), .branch_i(branch)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    {ir_en, opnd_en, s_en, m_en, mem_we, rf_we, pc_en, branch, tb_we} = '0;
  endtask

  function automatic logic [31:0] rtype(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] a, b);
    case (fn)
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic poke(input logic [5:0] idx, input logic [31:0] v);
    tb_we = 1; tb_wa = idx; tb_wd = v; cycle();
  endtask
  task automatic fetch(input logic [31:0] w);
    imem[imem_addr[7:2]] = w; ir_en = 1; cycle();
  endtask
  task automatic opnd();                  opnd_en = 1; cycle(); endtask
  task automatic exec(input logic [1:0] s); alu_sel = s; s_en = 1; cycle(); endtask
  task automatic memrd();                 m_en = 1; cycle(); endtask
  task automatic memwr();                 mem_we = 1; cycle(); endtask
  task automatic wb(input logic to_rd, input logic from_m);
    dst_sel = to_rd; wb_sel = from_m; rf_we = 1; cycle();
  endtask
  task automatic pcup(input logic br); branch = br; pc_en = 1; cycle(); endtask

  task automatic set_reg(input logic [4:0] r, input logic [31:0] v);
    poke(6'd60, v);
    fetch(itype(6'h23, 5'd0, r, 16'd240));
    opnd(); exec(2'd2); memrd(); wb(1'b0, 1'b1); pcup(1'b0);
  endtask
  task automatic get_reg(input logic [4:0] r, output logic [31:0] v);
    fetch(itype(6'h2b, 5'd0, r, 16'd248));
    opnd(); v = dmem_wdata; exec(2'd2); memwr(); pcup(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] vals [6];
    logic [31:0] v, pc0, exp_pc;
    logic [5:0]  fns [6];
    vals = '{32'h0, 32'h1, 32'h7, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
    fns  = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h3F};
    for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 pc reset", imem_addr, 32'h0);
    chk("R1 s reset", dmem_addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    get_reg(5'd7, v);
    chk("R1 regfile reset", v, 32'h0);
    chk("R10 pc seq", imem_addr, 32'd4);

    // R4 R6 R3 R10 sweep over operand pairs and function codes
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        set_reg(5'd1, vals[i]);
        set_reg(5'd2, vals[j]);
        for (int k = 0; k < 6; k++) begin
          fetch(rtype(5'd1, 5'd2, 5'd3, fns[k]));
          opnd();
          exec(2'd0);
          chk("R4 alu func", dmem_addr, ref_alu(fns[k], vals[i], vals[j]));
        end
        wb(1'b1, 1'b0);
        get_reg(5'd3, v);
        chk("R8 rd write", v, 32'h0);
        fetch(rtype(5'd1, 5'd2, 5'd3, 6'h3F));
        opnd();
        pc0 = imem_addr;
        exp_pc = pc0 + 32'd4 + ((vals[i] == vals[j]) ? {14'd0, 16'h183F, 2'b00} : 32'd0);
        pcup(1'b1);
        chk("R3 eq flag via branch", imem_addr, exp_pc);
      end
    end

    // R5 extenders
    set_reg(5'd1, 32'h1234_0000);
    set_reg(5'd16, 32'hCAFE_0016);
    fetch(itype(6'h0d, 5'd1, 5'd4, 16'h8001));
    opnd(); exec(2'd1);
    chk("R5 or zero-ext", dmem_addr, 32'h1234_8001);
    wb(1'b0, 1'b0); pcup(1'b0);
    get_reg(5'd4, v);
    chk("R8 rt write", v, 32'h1234_8001);
    get_reg(5'd16, v);
    chk("R8 rd untouched", v, 32'hCAFE_0016);
    fetch(itype(6'h08, 5'd1, 5'd4, 16'hFFFC));
    opnd(); exec(2'd2);
    chk("R5 add sign-ext", dmem_addr, 32'h1233_FFFC);
    exec(2'd3);
    chk("R5 sel zero", dmem_addr, 32'h0);
    pcup(1'b0);

    // R9 register zero
    set_reg(5'd2, 32'h5555_AAAA);
    fetch(rtype(5'd2, 5'd2, 5'd0, 6'h20));
    opnd(); exec(2'd0); wb(1'b1, 1'b0); pcup(1'b0);
    get_reg(5'd0, v);
    chk("R9 r0 after write", v, 32'h0);
    set_reg(5'd0, 32'hDEAD_BEEF);
    get_reg(5'd0, v);
    chk("R9 r0 after load", v, 32'h0);

    // R2 R11 instruction register gating
    set_reg(5'd1, 32'd11);
    set_reg(5'd2, 32'd22);
    fetch(rtype(5'd1, 5'd2, 5'd3, 6'h22));
    imem[imem_addr[7:2]] = rtype(5'd2, 5'd1, 5'd3, 6'h20);
    opnd(); exec(2'd0);
    chk("R2 ir held", dmem_addr, 32'hFFFF_FFF5);
    opnd();
    chk("R11 s held", dmem_addr, 32'hFFFF_FFF5);
    pc0 = imem_addr;
    repeat (4) cycle();
    chk("R11 pc held", imem_addr, pc0);
    pcup(1'b0);

    // R7 load and store
    set_reg(5'd9, 32'h0BAD_F00D);
    get_reg(5'd9, v);
    chk("R7 store data port", v, 32'h0BAD_F00D);
    chk("R7 store memory", dmem[62], 32'h0BAD_F00D);
    chk("R7 store address", dmem_addr, 32'd248);

    // R10 branches
    set_reg(5'd5, 32'd9);
    set_reg(5'd6, 32'd9);
    set_reg(5'd7, 32'd8);
    fetch(itype(6'h04, 5'd5, 5'd6, 16'd3)); opnd();
    pc0 = imem_addr; pcup(1'b1);
    chk("R10 taken fwd", imem_addr, pc0 + 32'd16);
    fetch(itype(6'h04, 5'd5, 5'd6, 16'hFFFE)); opnd();
    pc0 = imem_addr; pcup(1'b1);
    chk("R10 taken back", imem_addr, pc0 - 32'd4);
    fetch(itype(6'h04, 5'd5, 5'd7, 16'd3)); opnd();
    pc0 = imem_addr; pcup(1'b1);
    chk("R10 not taken", imem_addr, pc0 + 32'd4);
    fetch(itype(6'h04, 5'd5, 5'd6, 16'd3)); opnd();
    pc0 = imem_addr; pcup(1'b0);
    chk("R10 branch off", imem_addr, pc0 + 32'd4);

    // R1 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R1 async pc clear", imem_addr, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    get_reg(5'd5, v);
    chk("R1 regfile cleared", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule